// File: doc/BRIEF.md
# Enclave Translation Fill Gate

This block sits behind a hardware page walker and decides whether a finished translation may be written into the TLB. Each walk result arrives on a valid/ready stream. It carries the physical address, the virtual page number and the requester's enclave-mode flag and enclave identifier. The block checks the physical address against a protected memory range, given as a base and a mask, and against a contiguous region of 4 KiB enclave pages. For pages inside that region it reads a per-page metadata table. The table has a write port, and each entry holds a valid bit, a blocked bit, a page type, an owner identifier and the virtual page number recorded when the page was allocated.

The checks run in a fixed priority order. The first failing check gives a 3-bit fault code. If every check passes, the result asserts the fill enable. The decision leaves the block one cycle after acceptance on a registered valid/ready output stream.

Back-pressure works as follows. A result is held, unchanged, until the consumer takes it with `res_ready`. While a result is held and not taken, `walk_ready` is low. While a result is being taken, `walk_ready` is high, so the stream can accept one walk per cycle. A metadata write changes the table at the next clock edge. It therefore affects only walks accepted after that edge.

Top module: `enclave_fill_gate`

## Requirements
- R1: After reset `res_valid` is low, `walk_ready` is high and every metadata entry is invalid.
- R2: A walk is accepted when `walk_valid` and `walk_ready` are both high at a clock edge. Its result appears on `res_valid`/`res_code`/`res_fill` from the next edge. It stays unchanged while `res_ready` is low. `walk_ready` equals `!res_valid || res_ready`.
- R3: With `walk_enclave` low, a physical address inside the protected range (`(pa ^ cfg_prot_base) & cfg_prot_mask == 0`) gives code 1. Any other address gives code 0.
- R4: With `walk_enclave` high, a physical address outside the protected range gives code 0.
- R5: With `walk_enclave` high and the address inside the protected range, code 2 is given in either of two cases. The first is that the page number minus `cfg_region_ppn` is not below the entry count (64). The second is that the indexed entry is invalid.
- R6: An enclave walk to a valid entry whose blocked bit is set gives code 3.
- R7: An enclave walk to a valid, unblocked entry whose type is 2 or 3 (not accessible to software) gives code 4. Types 0 and 1 are accessible.
- R8: An enclave walk passing R5 to R7 whose entry owner differs from `walk_eid` gives code 5.
- R9: An enclave walk passing R5 to R8 whose `walk_vpn` differs from the entry's recorded virtual page gives code 6. Otherwise the walk gives code 0.
- R10: When several checks fail, the reported code is the lowest-numbered failing check, in the order 2, 3, 4, 5, 6.
- R11: `res_fill` is high exactly when `res_code` is 0.
- R12: A write with `meta_we` high stores the fields at entry `meta_idx`. The entry index of a walk is its page number minus `cfg_region_ppn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prot_base | input | 32 | Protected range base |
| cfg_prot_mask | input | 32 | Protected range mask (ones select compared bits) |
| cfg_region_ppn | input | 20 | First physical page number of the enclave page region |
| meta_we | input | 1 | Metadata write strobe |
| meta_idx | input | 6 | Metadata entry to write |
| meta_valid | input | 1 | Entry valid |
| meta_blocked | input | 1 | Entry blocked (being evicted) |
| meta_type | input | 2 | Page type, 2 and 3 inaccessible |
| meta_owner | input | 8 | Owning enclave identifier |
| meta_vpn | input | 20 | Virtual page recorded at allocation |
| walk_valid | input | 1 | Walk result valid |
| walk_ready | output | 1 | Walk result accepted |
| walk_pa | input | 32 | Physical address from the walk |
| walk_vpn | input | 20 | Virtual page number of the request |
| walk_enclave | input | 1 | Requester in enclave mode |
| walk_eid | input | 8 | Requester enclave identifier |
| res_valid | output | 1 | Decision valid |
| res_ready | input | 1 | Decision consumed |
| res_fill | output | 1 | TLB fill permitted |
| res_code | output | 3 | Fault code, 0 when allowed |

## Verification
The assertions check five behaviours on every cycle:
- a held decision stays stable under back-pressure;
- every accepted walk gives a result one cycle later;
- a host-mode walk inside the protected range gives code 1, and an enclave-mode walk never gives it;
- an enclave walk outside the protected range is allowed;
- a blocked valid page gives code 3.

Only the bench's scenarios can show the priority order when several checks fail at once. The same holds for the region edges at entry 63 and entry 64, for the read-after-write timing of the metadata table, and for the type, owner and virtual-page codes. The bench also checks that table contents after reset are invalid.

// File: rtl/efg_pkg.sv
package efg_pkg;
  typedef enum logic [2:0] {
    FC_ALLOW        = 3'd0,
    FC_HOST_PROT    = 3'd1,
    FC_NOT_EPAGE    = 3'd2,
    FC_BLOCKED      = 3'd3,
    FC_NO_ACCESS    = 3'd4,
    FC_OWNER        = 3'd5,
    FC_VPAGE        = 3'd6
  } fault_e;

  typedef enum logic [1:0] {
    PT_REGULAR = 2'd0,
    PT_THREAD  = 2'd1,
    PT_CONTROL = 2'd2,
    PT_RESERVE = 2'd3
  } ptype_e;
endpackage

// File: rtl/efg_page_table.sv
module efg_page_table #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6,
  parameter int EID_W   = 8,
  parameter int VPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_blocked,
  input  logic [1:0]       wr_type,
  input  logic [EID_W-1:0] wr_owner,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_blocked,
  output logic [1:0]       rd_type,
  output logic [EID_W-1:0] rd_owner,
  output logic [VPN_W-1:0] rd_vpn
);
  logic             valid_q   [ENTRIES];
  logic             blocked_q [ENTRIES];
  logic [1:0]       type_q    [ENTRIES];
  logic [EID_W-1:0] owner_q   [ENTRIES];
  logic [VPN_W-1:0] vpn_q     [ENTRIES];

  // state bits reset so every entry starts invalid
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        valid_q[e]   <= 1'b0;
        blocked_q[e] <= 1'b0;
      end
    end else if (wr_en) begin
      valid_q[wr_idx]   <= wr_valid;
      blocked_q[wr_idx] <= wr_blocked;
    end
  end

  // payload fields carry no reset; they are ignored while invalid
  always_ff @(posedge clk) begin
    if (wr_en) begin
      type_q[wr_idx]  <= wr_type;
      owner_q[wr_idx] <= wr_owner;
      vpn_q[wr_idx]   <= wr_vpn;
    end
  end

  assign rd_valid   = valid_q[rd_idx];
  assign rd_blocked = blocked_q[rd_idx];
  assign rd_type    = type_q[rd_idx];
  assign rd_owner   = owner_q[rd_idx];
  assign rd_vpn     = vpn_q[rd_idx];
endmodule

// File: rtl/efg_region_decode.sv
module efg_region_decode #(
  parameter int PA_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int ENTRIES  = 64,
  parameter int IDX_W    = 6,
  localparam int PPN_W   = PA_W - PG_SHIFT
) (
  input  logic [PA_W-1:0]  pa,
  input  logic [PA_W-1:0]  prot_base,
  input  logic [PA_W-1:0]  prot_mask,
  input  logic [PPN_W-1:0] region_ppn,
  output logic             in_prot,
  output logic             in_region,
  output logic [IDX_W-1:0] idx
);
  logic [PPN_W-1:0] page_off;

  assign in_prot  = ((pa ^ prot_base) & prot_mask) == '0;
  assign page_off = pa[PA_W-1:PG_SHIFT] - region_ppn;
  assign idx      = page_off[IDX_W-1:0];

  generate
    if (ENTRIES == (1 << IDX_W)) begin : g_pow2
      assign in_region = page_off[PPN_W-1:IDX_W] == '0;
    end else begin : g_cmp
      assign in_region = page_off < PPN_W'(ENTRIES);
    end
  endgenerate
endmodule

// File: rtl/efg_check_chain.sv
module efg_check_chain
  import efg_pkg::*;
#(
  parameter int EID_W = 8,
  parameter int VPN_W = 20
) (
  input  logic             enclave,
  input  logic [EID_W-1:0] req_eid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             in_prot,
  input  logic             in_region,
  input  logic             pg_valid,
  input  logic             pg_blocked,
  input  logic [1:0]       pg_type,
  input  logic [EID_W-1:0] pg_owner,
  input  logic [VPN_W-1:0] pg_vpn,
  output fault_e           code
);
  logic no_sw_access;

  // control and reserved types are never reachable by software
  assign no_sw_access = (pg_type == PT_CONTROL) || (pg_type == PT_RESERVE);

  always_comb begin
    code = FC_ALLOW;
    if (!enclave) begin
      if (in_prot) code = FC_HOST_PROT;
    end else if (in_prot) begin
      if (!in_region || !pg_valid)  code = FC_NOT_EPAGE;
      else if (pg_blocked)          code = FC_BLOCKED;
      else if (no_sw_access)        code = FC_NO_ACCESS;
      else if (pg_owner != req_eid) code = FC_OWNER;
      else if (pg_vpn != req_vpn)   code = FC_VPAGE;
    end
  end
endmodule

// File: rtl/enclave_fill_gate.sv
module enclave_fill_gate
  import efg_pkg::*;
#(
  parameter int PA_W     = 32,
  parameter int VA_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int ENTRIES  = 64,
  parameter int EID_W    = 8,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int PPN_W   = PA_W - PG_SHIFT,
  localparam int VPN_W   = VA_W - PG_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  cfg_prot_base,
  input  logic [PA_W-1:0]  cfg_prot_mask,
  input  logic [PPN_W-1:0] cfg_region_ppn,
  input  logic             meta_we,
  input  logic [IDX_W-1:0] meta_idx,
  input  logic             meta_valid,
  input  logic             meta_blocked,
  input  logic [1:0]       meta_type,
  input  logic [EID_W-1:0] meta_owner,
  input  logic [VPN_W-1:0] meta_vpn,
  input  logic             walk_valid,
  output logic             walk_ready,
  input  logic [PA_W-1:0]  walk_pa,
  input  logic [VPN_W-1:0] walk_vpn,
  input  logic             walk_enclave,
  input  logic [EID_W-1:0] walk_eid,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_fill,
  output logic [2:0]       res_code
);
  logic             in_prot, in_region;
  logic [IDX_W-1:0] pg_idx;
  logic             pg_valid, pg_blocked;
  logic [1:0]       pg_type;
  logic [EID_W-1:0] pg_owner;
  logic [VPN_W-1:0] pg_vpn;
  fault_e           chk_code;
  logic             accept;

  efg_region_decode #(
    .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_decode (
    .pa(walk_pa), .prot_base(cfg_prot_base), .prot_mask(cfg_prot_mask),
    .region_ppn(cfg_region_ppn), .in_prot(in_prot), .in_region(in_region),
    .idx(pg_idx)
  );

  efg_page_table #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .EID_W(EID_W), .VPN_W(VPN_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(meta_we), .wr_idx(meta_idx), .wr_valid(meta_valid),
    .wr_blocked(meta_blocked), .wr_type(meta_type), .wr_owner(meta_owner),
    .wr_vpn(meta_vpn),
    .rd_idx(pg_idx), .rd_valid(pg_valid), .rd_blocked(pg_blocked),
    .rd_type(pg_type), .rd_owner(pg_owner), .rd_vpn(pg_vpn)
  );

  efg_check_chain #(.EID_W(EID_W), .VPN_W(VPN_W)) u_chain (
    .enclave(walk_enclave), .req_eid(walk_eid), .req_vpn(walk_vpn),
    .in_prot(in_prot), .in_region(in_region), .pg_valid(pg_valid),
    .pg_blocked(pg_blocked), .pg_type(pg_type), .pg_owner(pg_owner),
    .pg_vpn(pg_vpn), .code(chk_code)
  );

  assign walk_ready = !res_valid || res_ready;
  assign accept     = walk_valid && walk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_fill  <= 1'b0;
      res_code  <= 3'd0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_fill  <= (chk_code == FC_ALLOW);
      res_code  <= chk_code;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_code) && $stable(res_fill));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);

  assert_host_prot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !walk_enclave && in_prot |=> res_code == 3'd1 && !res_fill);

  assert_enclave_no_code1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && walk_enclave |=> res_code != 3'd1);

  assert_outside_allow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && walk_enclave && !in_prot |=> res_fill && res_code == 3'd0);

  assert_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && walk_enclave && in_prot && in_region && pg_valid && pg_blocked
    |=> res_code == 3'd3 && !res_fill);
endmodule

// File: tb/tb_enclave_fill_gate.sv
module tb_enclave_fill_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PBASE = 32'h8000_0000;
  localparam logic [31:0] PMASK = 32'hF000_0000;
  localparam logic [19:0] RPPN  = 20'h80100;
  localparam logic [19:0] VBASE = 20'h40000;

  logic clk = 0, rst_n = 0;
  logic meta_we = 0, meta_valid = 0, meta_blocked = 0;
  logic [5:0] meta_idx = 0;
  logic [1:0] meta_type = 0;
  logic [7:0] meta_owner = 0;
  logic [19:0] meta_vpn = 0;
  logic walk_valid = 0, walk_enclave = 0;
  logic [31:0] walk_pa = 0;
  logic [19:0] walk_vpn = 0;
  logic [7:0] walk_eid = 0;
  logic walk_ready, res_valid, res_fill;
  logic res_ready = 1;
  logic [2:0] res_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  enclave_fill_gate dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_prot_base(PBASE), .cfg_prot_mask(PMASK), .cfg_region_ppn(RPPN),
    .meta_we(meta_we), .meta_idx(meta_idx), .meta_valid(meta_valid),
    .meta_blocked(meta_blocked), .meta_type(meta_type), .meta_owner(meta_owner),
    .meta_vpn(meta_vpn),
    .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_pa(walk_pa),
    .walk_vpn(walk_vpn), .walk_enclave(walk_enclave), .walk_eid(walk_eid),
    .res_valid(res_valid), .res_ready(res_ready), .res_fill(res_fill),
    .res_code(res_code)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit bp_on = 0;

  typedef struct { logic [2:0] code; string tag; } exp_t;
  exp_t sb[$];

  // bench-side model of the metadata table
  logic        mv [64];
  logic        mb [64];
  logic [1:0]  mt [64];
  logic [7:0]  mo [64];
  logic [19:0] mp [64];

  function automatic logic [2:0] model(logic [31:0] pa, logic [19:0] vpn,
                                       logic enc, logic [7:0] eid);
    logic inp, inr;
    logic [19:0] off;
    int i;
    inp = (pa & PMASK) == PBASE;
    off = pa[31:12] - RPPN;
    inr = off < 20'd64;
    i = int'(off[5:0]);
    if (!enc) return inp ? 3'd1 : 3'd0;
    if (!inp) return 3'd0;
    if (!inr || !mv[i]) return 3'd2;
    if (mb[i]) return 3'd3;
    if (mt[i] >= 2'd2) return 3'd4;
    if (mo[i] != eid) return 3'd5;
    if (mp[i] != vpn) return 3'd6;
    return 3'd0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic v, logic b, logic [1:0] t, logic [7:0] o,
                    logic [19:0] p);
    @(negedge clk);
    meta_we = 1; meta_idx = 6'(idx); meta_valid = v; meta_blocked = b;
    meta_type = t; meta_owner = o; meta_vpn = p;
    @(negedge clk);
    meta_we = 0;
    mv[idx] = v; mb[idx] = b; mt[idx] = t; mo[idx] = o; mp[idx] = p;
  endtask

  task automatic send(logic [31:0] pa, logic [19:0] vpn, logic enc,
                      logic [7:0] eid, string tag);
    bit rdy;
    exp_t e;
    forever begin
      @(negedge clk);
      walk_valid = 1; walk_pa = pa; walk_vpn = vpn;
      walk_enclave = enc; walk_eid = eid;
      rdy = walk_ready;
      @(posedge clk);
      if (rdy) break;
    end
    e.code = model(pa, vpn, enc, eid);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    walk_valid = 0;
  endtask

  function automatic logic [31:0] pg(int i);
    return {RPPN + 20'(i), 12'h0};
  endfunction

  // consumer ready, changed only just after a rising edge
  always @(posedge clk) begin
    #1;
    res_ready = bp_on ? 1'($urandom % 2) : 1'b1;
  end

  // monitor: pops and compares; also checks hold under back-pressure
  logic prev_stall = 0;
  logic [2:0] prev_code = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(res_valid && res_code == prev_code, "R2 hold under stall",
              int'(res_code), int'(prev_code));
      if (res_valid && res_ready) begin
        if (sb.size() == 0) begin
          check(0, "R2 unexpected result", int'(res_code), -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(res_code == e.code, e.tag, int'(res_code), int'(e.code));
          check(res_fill == (e.code == 3'd0), "R11 fill vs code",
                int'(res_fill), int'(e.code == 3'd0));
        end
      end
      prev_stall = res_valid && !res_ready;
      prev_code = res_code;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mv[i] = 0; mb[i] = 0; mt[i] = 0; mo[i] = 0; mp[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!res_valid, "R1 res_valid after reset", int'(res_valid), 0);
    check(walk_ready, "R1 walk_ready after reset", int'(walk_ready), 1);

    // R1 / R5: untouched entry reads invalid
    send(pg(5), VBASE + 20'd5, 1, 8'd1, "R1 entry invalid after reset");
    idle();
    check(res_valid, "R2 result one cycle after accept", int'(res_valid), 1);

    // R3 host mode
    send(32'h1000_2000, 20'h10002, 0, 8'd0, "R3 host outside prot");
    send(pg(3), VBASE + 20'd3, 0, 8'd0, "R3 host inside region");
    send(32'h8000_0000, 20'h0, 0, 8'd0, "R3 host inside prot");
    // R4 enclave outside prot
    send(32'h2000_0000, 20'h20000, 1, 8'd1, "R4 enclave outside prot");
    // R5 inside prot, outside region
    send(32'h8000_0000, VBASE, 1, 8'd1, "R5 prot not region");
    idle();

    // R12 populate entries
    wr(0, 1, 0, 2'd0, 8'd1, VBASE);
    wr(1, 1, 1, 2'd0, 8'd1, VBASE + 20'd1);
    wr(2, 1, 0, 2'd2, 8'd1, VBASE + 20'd2);
    wr(3, 1, 0, 2'd3, 8'd1, VBASE + 20'd3);
    wr(4, 1, 0, 2'd1, 8'd2, VBASE + 20'd4);
    wr(6, 1, 1, 2'd2, 8'd2, VBASE + 20'd7);
    wr(7, 1, 0, 2'd3, 8'd2, VBASE);
    wr(8, 1, 0, 2'd0, 8'd2, VBASE);
    wr(63, 1, 0, 2'd0, 8'd1, VBASE + 20'd63);

    send(pg(0), VBASE, 1, 8'd1, "R12 written entry allowed");
    send(pg(1), VBASE + 20'd1, 1, 8'd1, "R6 blocked");
    send(pg(2), VBASE + 20'd2, 1, 8'd1, "R7 type 2");
    send(pg(3), VBASE + 20'd3, 1, 8'd1, "R7 type 3");
    send(pg(4), VBASE + 20'd4, 1, 8'd1, "R8 owner mismatch");
    send(pg(4), VBASE + 20'd4, 1, 8'd2, "R7 type 1 accessible");
    send(pg(0), VBASE + 20'd9, 1, 8'd1, "R9 vpage mismatch");
    send(pg(6), VBASE + 20'd6, 1, 8'd1, "R10 blocked over type/owner/va");
    send(pg(7), VBASE + 20'd7, 1, 8'd1, "R10 type over owner/va");
    send(pg(8), VBASE + 20'd8, 1, 8'd1, "R10 owner over va");
    send(pg(63), VBASE + 20'd63, 1, 8'd1, "R5 last entry inside");
    send(pg(64), VBASE + 20'd64, 1, 8'd1, "R5 first page past region");
    idle();

    // R12 invalidate then read back
    wr(0, 0, 0, 2'd0, 8'd1, VBASE);
    send(pg(0), VBASE, 1, 8'd1, "R12 entry cleared");
    idle();

    // random stream with back-pressure
    for (int i = 0; i < 64; i++)
      wr(i, 1'($urandom % 4 != 0), 1'($urandom % 5 == 0), 2'($urandom),
         8'($urandom % 2 + 1), VBASE + 20'(i + ($urandom % 6 == 0)));
    bp_on = 1;
    for (int n = 0; n < 300; n++) begin
      int i;
      i = int'($urandom % 68);
      send(pg(i), VBASE + 20'(i), 1'($urandom % 4 != 0),
           8'($urandom % 2 + 1), "R10 random stream");
    end
    idle();
    bp_on = 0;
    repeat (20) @(negedge clk);
    check(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule